// File: doc/BRIEF.md
# GPIO Bank with Set/Clear Aliases

One bank of up to 32 general-purpose pins, controlled over a small memory-mapped register bus. Software drives pin levels through a data-out register and turns pins into outputs through an output-enable register. It reads the synchronized pin levels from a data-in register. Every register can be changed bit by bit without a read-modify-write: each one has a plain address, a set address and a clear address.

Every pin can be an interrupt source. Two per-pin registers, a level bit and a polarity bit, together form a 2-bit trigger code. That code selects rising edge, falling edge, high level or low level. A pin records a hit in its status bit only while it is both routed to the interrupt logic and enabled. The bank has one combined interrupt output.

Reads are combinational from the address. Writes take effect on the rising clock edge where `req_i` and `we_i` are both high.

Top module: `gpio_bank_sa`

## Requirements
- R1: After reset, every register reads 0, `pin_o`, `pin_oe_o` and `irq_o` are 0, and data-in reads 0 while all pins are low.
- R2: Register k is at byte address 0x10*k, with k = 0 data-out, 1 data-in, 2 output-enable, 3 route-to-interrupt, 4 interrupt-enable, 5 level, 6 polarity, 7 status. Writing base+0 loads the whole value. Writing base+4 sets the bits written as 1. Writing base+8 clears the bits written as 1. A read of base+0, +4 or +8 returns the register value.
- R3: A set or clear write to data-out changes only the bits written as 1. `pin_o` always equals data-out.
- R4: A 1 in an output-enable bit drives that bit of `pin_oe_o` high, so the pin is an output. Clearing the bit drops it again.
- R5: Data-in returns each pin through a two-flop synchronizer. A pin change is visible after the second rising edge that follows it, and not after the first. Writes to any data-in address are ignored.
- R6: The trigger code is {polarity, level}: 0 is falling edge, 1 is low level, 2 is rising edge, 3 is high level. A status bit sets on the third rising edge after the pin change that meets its code. An edge sets it only once.
- R7: A status bit can be set by its pin only when both the route-to-interrupt bit and the interrupt-enable bit of that pin are 1.
- R8: In level mode the status bit is set again on every cycle while the level persists. A set event beats a clear write in the same cycle.
- R9: A clear-alias write to status clears exactly the bits written as 1. Writing all ones clears every pending bit.
- R10: `irq_o` is high when some status bit is 1 and its interrupt-enable bit is 1. Dropping the enable bit hides a pending status bit but does not clear it.
- R11: Offset +0xC of every register, and every address at or above 0x80, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | NPIN | Write data |
| rdata_o | output | NPIN | Read data, combinational from addr_i |
| pin_i | input | NPIN | Asynchronous pin levels |
| pin_o | output | NPIN | Data-out value to pads |
| pin_oe_o | output | NPIN | Per-pin output enable |
| irq_o | output | 1 | Combined bank interrupt |

## Verification
A register write becomes visible on the read port and on `pin_o`/`pin_oe_o` at the clock edge that accepts it, so the bench samples one half-period after that edge. A pin change shows up in data-in after two edges and in status and `irq_o` after three. For each interrupt case the bench therefore checks at edge two that status is still clear, and at edge three that it is set. Every sample is taken at a falling edge, and each check counts edges from the falling edge at which the stimulus was applied.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned NREG = 8;

  typedef enum logic [2:0] {
    REG_DOUT = 3'd0,
    REG_DIN  = 3'd1,
    REG_OE   = 3'd2,
    REG_P2I  = 3'd3,
    REG_IEN  = 3'd4,
    REG_LVL  = 3'd5,
    REG_POL  = 3'd6,
    REG_STAT = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    AL_WR   = 2'd0,
    AL_SET  = 2'd1,
    AL_CLR  = 2'd2,
    AL_NONE = 2'd3
  } alias_e;
endpackage

// File: rtl/gpio_bank_dec.sv
module gpio_bank_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   wsel_o,
  output alias_e            alias_o,
  output logic [2:0]        ridx_o,
  output logic              rhit_o
);
  localparam int unsigned HI_W = ADDR_W - 4;

  logic [HI_W-1:0] hi;
  logic            mapped;

  assign hi      = addr_i[ADDR_W-1:4];
  assign mapped  = hi < HI_W'(NREG);
  assign alias_o = alias_e'(addr_i[3:2]);
  assign rhit_o  = mapped && (alias_o != AL_NONE);
  assign ridx_o  = hi[2:0];

  for (genvar g = 0; g < NREG; g++) begin : g_wsel
    assign wsel_o[g] = req_i && we_i && rhit_o && (hi == HI_W'(g));
  end
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_o <= '0;
      prev_o <= '0;
    end else begin
      meta_q <= async_i;
      sync_o <= meta_q;
      prev_o <= sync_o;
    end
  end
endmodule

// File: rtl/gpio_bank_trig.sv
module gpio_bank_trig #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] arm_i,
  output logic [W-1:0] hit_o
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    logic at_pol;
    logic moved;
    assign at_pol   = sync_i[p] == pol_i[p];
    assign moved    = sync_i[p] != prev_i[p];
    // level: polarity match alone; edge: match plus change
    assign hit_o[p] = arm_i[p] && at_pol && (lvl_i[p] || moved);
  end
endmodule

// File: rtl/gpio_bank_creg.sv
module gpio_bank_creg
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wen_i,
  input  alias_e       alias_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] sw_d;

  always_comb begin
    sw_d = q_o;
    if (wen_i) begin
      unique case (alias_i)
        AL_WR:   sw_d = wdata_i;
        AL_SET:  sw_d = q_o | wdata_i;
        AL_CLR:  sw_d = q_o & ~wdata_i;
        default: sw_d = q_o;
      endcase
    end
  end

  // hardware set beats any software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= sw_d | hw_set_i;
  end
endmodule

// File: rtl/gpio_bank_sa.sv
module gpio_bank_sa
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPIN   = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPIN-1:0]   wdata_i,
  output logic [NPIN-1:0]   rdata_o,
  input  logic [NPIN-1:0]   pin_i,
  output logic [NPIN-1:0]   pin_o,
  output logic [NPIN-1:0]   pin_oe_o,
  output logic              irq_o
);
  logic [NREG-1:0] wsel;
  alias_e          alias_w;
  logic [2:0]      ridx;
  logic            rhit;

  logic [NPIN-1:0] sync_w, prev_w, hit_w, arm_w;
  logic [NPIN-1:0] regq [NREG];
  logic [NPIN-1:0] stat_q, ien_q, p2i_q;

  gpio_bank_dec #(.ADDR_W(ADDR_W)) u_dec (
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wsel_o (wsel),
    .alias_o(alias_w),
    .ridx_o (ridx),
    .rhit_o (rhit)
  );

  gpio_bank_sync #(.W(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pin_i),
    .sync_o (sync_w),
    .prev_o (prev_w)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == int'(REG_DIN)) begin : g_din
      assign regq[g] = sync_w;
    end else begin : g_ctl
      logic [NPIN-1:0] hw_set;
      if (g == int'(REG_STAT)) begin : g_hw
        assign hw_set = hit_w;
      end else begin : g_sw
        assign hw_set = '0;
      end
      gpio_bank_creg #(.W(NPIN)) u_reg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wen_i   (wsel[g]),
        .alias_i (alias_w),
        .wdata_i (wdata_i),
        .hw_set_i(hw_set),
        .q_o     (regq[g])
      );
    end
  end

  assign stat_q = regq[REG_STAT];
  assign ien_q  = regq[REG_IEN];
  assign p2i_q  = regq[REG_P2I];
  assign arm_w  = p2i_q & ien_q;

  gpio_bank_trig #(.W(NPIN)) u_trig (
    .sync_i(sync_w),
    .prev_i(prev_w),
    .lvl_i (regq[REG_LVL]),
    .pol_i (regq[REG_POL]),
    .arm_i (arm_w),
    .hit_o (hit_w)
  );

  assign rdata_o  = rhit ? regq[ridx] : '0;
  assign pin_o    = regq[REG_DOUT];
  assign pin_oe_o = regq[REG_OE];
  assign irq_o    = |(stat_q & ien_q);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned NPIN   = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NPIN-1:0]   wdata_i,
  input logic [NPIN-1:0]   pin_o,
  input logic [NPIN-1:0]   pin_oe_o,
  input logic              irq_o,
  input logic [NPIN-1:0]   stat_q,
  input logic [NPIN-1:0]   ien_q,
  input logic [NPIN-1:0]   p2i_q
);
  logic wr;
  logic [ADDR_W-3:0] wa;
  assign wr = req_i && we_i;
  assign wa = addr_i[ADDR_W-1:2];

  logic dout_set, dout_clr, oe_clr, stat_wr;
  assign dout_set = wr && (wa == (ADDR_W-2)'(1));
  assign dout_clr = wr && (wa == (ADDR_W-2)'(2));
  assign oe_clr   = wr && (wa == (ADDR_W-2)'(10));
  assign stat_wr  = wr && (addr_i[ADDR_W-1:4] == (ADDR_W-4)'(7));

  AST_ARM_GATES_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(stat_wr) |-> ((stat_q & ~$past(stat_q) & ~$past(p2i_q & ien_q)) == '0)); // R7
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ien_q != '0)); // R10
  AST_DOUT_SET_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dout_set) |-> (pin_o == ($past(pin_o) | $past(wdata_i)))); // R3
  AST_DOUT_CLR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dout_clr) |-> (pin_o == ($past(pin_o) & ~$past(wdata_i)))); // R3
  AST_OE_CLR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(oe_clr) |-> (pin_oe_o == ($past(pin_oe_o) & ~$past(wdata_i)))); // R4
endmodule

bind gpio_bank_sa gpio_bank_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o),
  .irq_o   (irq_o),
  .stat_q  (stat_q),
  .ien_q   (ien_q),
  .p2i_q   (p2i_q)
);

// File: tb/sim_gpio_bank_sa.sv
`timescale 1ns/1ps
module sim_gpio_bank_sa;
  localparam int NPIN = 32;
  localparam int AW   = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NPIN-1:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_bank_sa #(.NPIN(NPIN), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  function automatic logic [AW-1:0] ra(int idx, int al);
    return AW'(idx * 16 + al * 4);
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic irq_case(int p, int mode);
    logic [31:0] v;
    logic idle;
    logic [31:0] b;
    b = 32'd1 << p;
    idle = mode[1] ? 1'b0 : 1'b1;
    pin_in[p] = idle;
    repeat (4) @(negedge clk);
    wr(ra(3, 1), b);
    wr(ra(4, 1), b);
    wr(ra(5, mode[0] ? 1 : 2), b);
    wr(ra(6, mode[1] ? 1 : 2), b);
    wr(ra(7, 2), 32'hffff_ffff);
    rd(ra(7, 0), v); chk("R9 idle clear", v, 0);
    pin_in[p] = ~idle;
    @(negedge clk); @(negedge clk);
    rd(ra(7, 0), v); chk("R6 early", v, 0);
    chk("R10 early irq", {31'd0, irq}, 0);
    @(negedge clk);
    rd(ra(7, 0), v); chk("R6 third edge", v, b);
    chk("R10 irq up", {31'd0, irq}, 1);
    wr(ra(7, 2), 32'hffff_ffff);
    if (mode[0]) begin
      rd(ra(7, 0), v); chk("R8 set beats clear", v, b);
    end else begin
      repeat (3) @(negedge clk);
      rd(ra(7, 0), v); chk("R6 edge once", v, 0);
    end
    pin_in[p] = idle;
    repeat (3) @(negedge clk);
    wr(ra(7, 2), 32'hffff_ffff);
    rd(ra(7, 0), v); chk("R9 cleared", v, 0);
    chk("R10 irq down", {31'd0, irq}, 0);
    wr(ra(3, 2), b);
    wr(ra(4, 2), b);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, acc, pat;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    for (int k = 0; k < 8; k++) begin
      rd(ra(k, 0), v); chk("R1 reg", v, 0);
    end
    chk("R1 pin_o", pin_out, 0);
    chk("R1 oe", pin_oe, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R3/R2 per-pin set then clear on data-out
    acc = 0;
    for (int i = 0; i < NPIN; i++) begin
      wr(ra(0, 1), 32'd1 << i);
      acc |= 32'd1 << i;
      chk("R3 set", pin_out, acc);
    end
    rd(ra(0, 4 / 4), v); chk("R2 set-alias read", v, 32'hffff_ffff);
    for (int i = 0; i < NPIN; i += 3) begin
      wr(ra(0, 2), 32'd1 << i);
      acc &= ~(32'd1 << i);
      chk("R3 clear", pin_out, acc);
    end
    rd(ra(0, 2), v); chk("R2 clr-alias read", v, acc);
    wr(ra(0, 0), 32'h1234_5678);
    rd(ra(0, 0), v); chk("R2 full write", v, 32'h1234_5678);

    // R4 output enable
    wr(ra(2, 0), 32'ha5a5_a5a5);
    chk("R4 oe write", pin_oe, 32'ha5a5_a5a5);
    wr(ra(2, 1), 32'h0000_ff00);
    chk("R4 oe set", pin_oe, 32'ha5a5_ffa5);
    wr(ra(2, 2), 32'hffff_0000);
    chk("R4 oe clear", pin_oe, 32'h0000_ffa5);
    rd(ra(2, 0), v); chk("R4 oe read", v, 32'h0000_ffa5);

    // R11 unmapped
    rd(8'h0c, v); chk("R11 gap read", v, 0);
    rd(8'h80, v); chk("R11 high read", v, 0);
    rd(8'hf4, v); chk("R11 top read", v, 0);
    wr(8'h0c, 32'hffff_ffff);
    chk("R11 gap write", pin_out, 32'h1234_5678);
    wr(8'h84, 32'hffff_ffff);
    chk("R11 high write", pin_out, 32'h1234_5678);

    // R5 synchronizer latency, writes to data-in ignored
    for (int k = 0; k < NPIN; k += 4) begin
      pat = (32'd1 << k) ^ 32'h0f0f_0000;
      acc = pin_in;
      pin_in = pat;
      @(negedge clk);
      rd(ra(1, 0), v); chk("R5 one edge", v, acc);
      @(negedge clk);
      rd(ra(1, 0), v); chk("R5 two edges", v, pat);
      wr(ra(1, 0), ~pat);
      wr(ra(1, 2), 32'hffff_ffff);
      rd(ra(1, 0), v); chk("R5 write ignored", v, pat);
    end
    pin_in = 0;
    repeat (4) @(negedge clk);

    // R6/R8/R9/R10 every trigger code on several pins
    foreach (u0.pin_o[i]) begin end
    for (int pi = 0; pi < 3; pi++) begin
      for (int m = 0; m < 4; m++) begin
        irq_case(pi == 0 ? 0 : (pi == 1 ? 13 : 31), m);
      end
    end
    pin_in = 0;
    repeat (4) @(negedge clk);

    // R7 arming, rising edge on pin 5
    wr(ra(5, 0), 0); wr(ra(6, 0), 32'd1 << 5);
    wr(ra(3, 0), 32'd1 << 5); wr(ra(4, 0), 0);
    pin_in[5] = 1; repeat (4) @(negedge clk);
    rd(ra(7, 0), v); chk("R7 route only", v, 0);
    pin_in[5] = 0; repeat (4) @(negedge clk);
    wr(ra(3, 0), 0); wr(ra(4, 0), 32'd1 << 5);
    pin_in[5] = 1; repeat (4) @(negedge clk);
    rd(ra(7, 0), v); chk("R7 enable only", v, 0);
    chk("R7 irq", {31'd0, irq}, 0);
    pin_in[5] = 0; repeat (4) @(negedge clk);
    wr(ra(3, 0), 32'd1 << 5);
    pin_in[5] = 1; repeat (4) @(negedge clk);
    rd(ra(7, 0), v); chk("R7 both", v, 32'd1 << 5);
    wr(ra(4, 2), 32'd1 << 5);
    chk("R10 masked irq", {31'd0, irq}, 0);
    rd(ra(7, 0), v); chk("R10 still pending", v, 32'd1 << 5);
    wr(ra(4, 1), 32'd1 << 5);
    chk("R10 unmasked irq", {31'd0, irq}, 1);

    // R9 selective and full clear, pins 2, 5, 9 rising
    wr(ra(6, 1), 32'h0000_0204);
    wr(ra(3, 1), 32'h0000_0204); wr(ra(4, 1), 32'h0000_0204);
    pin_in[2] = 1; pin_in[9] = 1; repeat (4) @(negedge clk);
    rd(ra(7, 0), v); chk("R9 pending", v, 32'h0000_0224);
    wr(ra(7, 2), 32'h0000_0004);
    rd(ra(7, 0), v); chk("R9 partial", v, 32'h0000_0220);
    wr(ra(7, 2), 32'hffff_ffff);
    rd(ra(7, 0), v); chk("R9 all", v, 0);
    chk("R9 irq", {31'd0, irq}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule